// File: doc/BRIEF.md
# Initialization Block Fetch Sequencer

This block is a bus-master sequencer that copies a controller's initialization block out of host memory. A single start pulse latches a base address, a structure-size select and a burst-read select. The sequencer then works through a series of short bus tenures. In each tenure it requests the bus, reads exactly two DWords and releases the bus again.

Every DWord it keeps is handed to the register file as an indexed write. With wide (32-bit) structures the block is seven DWords long and takes four tenures, and the eighth DWord read is dropped. With narrow (16-bit) structures it takes three tenures and six DWords. Both transfers of a tenure may share one address phase (burst) or each carry its own address phase (non-burst). The sequencer pulses `done` when the fetch is complete.

The bus is a simplified master interface: request and grant, a cycle-frame signal, an address phase and a data phase with a target-ready handshake. Retry, disconnect and full bus timing are not modelled.

Top module: `ibf_fetch_seq`

## Requirements
- R1: After reset, `bus_req`, `cyc`, `addr_valid`, `data_phase`, `wr_en` and `done` are all 0.
- R2: Each tenure completes exactly two data transfers (cycles with `data_phase` and `data_rdy` both 1), and `bus_req` falls right after the second one.
- R3: With `struct_wide`=1 a fetch takes four tenures and writes indices 0 to 6. The eighth DWord is read on the bus but produces no write.
- R4: With `struct_wide`=0 a fetch takes three tenures and writes indices 0 to 5.
- R5: With `burst_en`=0, every data phase is preceded by its own one-cycle address phase. `cyc` is 0 for the cycle after the first transfer of a tenure completes.
- R6: With `burst_en`=1, each tenure has one address phase. `cyc` stays 1 across both transfers and `addr[1:0]` is 0.
- R7: The address of transfer b (0 or 1) in tenure t is the base address with bits [1:0] cleared, plus 8*t plus 4*b. In burst mode only the b=0 address appears.
- R8: `bus_req` rises only when `bus_gnt` was 0 in the cycle before. Between tenures `bus_req` is 0 for at least one cycle.
- R9: `done` is a one-cycle pulse. It comes after the last kept write, once all tenures of the fetch are complete.
- R10: A `start` pulse while a fetch is in progress is ignored. The running fetch keeps its latched base, size and mode.
- R11: `cyc` is 1 only while `bus_gnt` is 1.
- R12: A data phase lasts until `data_rdy` is 1. `wr_en` is 1 only in such a cycle, with `wr_data` equal to `rd_data` and `wr_idx` counting up from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a fetch (used only when idle) |
| base_addr | input | 32 | Byte address of the initialization block |
| struct_wide | input | 1 | 1: 32-bit structures, 0: 16-bit structures |
| burst_en | input | 1 | 1: burst reads, 0: one address phase per DWord |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| cyc | output | 1 | Cycle frame, high during address and data phases |
| addr_valid | output | 1 | Address phase strobe |
| addr | output | 32 | DWord-aligned address, valid with `addr_valid` |
| data_phase | output | 1 | Master waiting for read data |
| data_rdy | input | 1 | Target supplies `rd_data` this cycle |
| rd_data | input | 32 | Read data from the bus |
| wr_en | output | 1 | Register-file write strobe |
| wr_idx | output | 3 | DWord index in the initialization block |
| wr_data | output | 32 | DWord to write |
| done | output | 1 | Fetch complete pulse |

## Verification
The bench targets the final tenure of a wide fetch. A design that miscounts there either writes a spurious eighth index or stops one tenure early and drops index 6.

It also checks the single-cycle frame drop between the two non-burst transfers and the absence of a second address phase in burst mode. A wrong phase choice shows up as a bad address-phase count or as `cyc` staying high.

Random wait states on `data_rdy` and random grant latency test that writes occur only on ready cycles and that the request is raised again only after the grant has dropped. A `start` pulse injected mid-fetch with a different base must leave every written address and value unchanged.

// File: rtl/ibf_pkg.sv
`timescale 1ns/1ps
package ibf_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_REQ, S_ADDR, S_DATA, S_GAP, S_REL, S_FIN
  } ibf_state_e;

  // Number of bus tenures for a structure size.
  function automatic int unsigned tenures_for(input logic wide);
    return wide ? 4 : 3;
  endfunction

  // Number of DWords actually kept for a structure size.
  function automatic int unsigned kept_for(input logic wide);
    return wide ? 7 : 6;
  endfunction

  // Byte offset of a transfer relative to the aligned base.
  function automatic int unsigned offset_of(input int unsigned ten, input int unsigned beat);
    return ten * 8 + beat * 4;
  endfunction
endpackage

// File: rtl/ibf_fsm.sv
`timescale 1ns/1ps
module ibf_fsm
  import ibf_pkg::*;
#(
  parameter int TENW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            wide_in,
  input  logic            burst_in,
  input  logic            bus_gnt,
  input  logic            data_rdy,
  output ibf_state_e      state,
  output logic [TENW-1:0] ten,
  output logic            beat,
  output logic            wide_q,
  output logic            burst_q,
  output logic            load
);
  logic [TENW-1:0] last_ten;
  logic            ack;

  assign load     = (state == S_IDLE) && start;
  assign ack      = (state == S_DATA) && data_rdy;
  assign last_ten = TENW'(tenures_for(wide_q) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      ten     <= '0;
      beat    <= 1'b0;
      wide_q  <= 1'b0;
      burst_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          wide_q  <= wide_in;
          burst_q <= burst_in;
          ten     <= '0;
          beat    <= 1'b0;
          state   <= S_REQ;
        end
        S_REQ:  if (bus_gnt) state <= S_ADDR;
        S_ADDR: state <= S_DATA;
        S_DATA: if (ack) begin
          if (!beat) begin
            beat  <= 1'b1;
            state <= burst_q ? S_DATA : S_GAP;
          end else begin
            beat  <= 1'b0;
            state <= S_REL;
          end
        end
        S_GAP:  state <= S_ADDR;
        S_REL:  if (!bus_gnt) begin
          if (ten == last_ten) state <= S_FIN;
          else begin
            ten   <= ten + 1'b1;
            state <= S_REQ;
          end
        end
        S_FIN:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ibf_addr_gen.sv
`timescale 1ns/1ps
module ibf_addr_gen
  import ibf_pkg::*;
#(
  parameter int AW   = 32,
  parameter int TENW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [AW-1:0]   base_in,
  input  logic [TENW-1:0] ten,
  input  logic            beat,
  output logic [AW-1:0]   cur_addr
);
  logic [AW-1:0] base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    base_q <= '0;
    else if (load) base_q <= {base_in[AW-1:2], 2'b00};
  end

  assign cur_addr = base_q + AW'(offset_of(int'(ten), int'(beat)));
endmodule

// File: rtl/ibf_wr_gate.sv
`timescale 1ns/1ps
module ibf_wr_gate
  import ibf_pkg::*;
#(
  parameter int DW   = 32,
  parameter int TENW = 2,
  parameter int IDXW = 3
) (
  input  logic            ack,
  input  logic            wide_q,
  input  logic [TENW-1:0] ten,
  input  logic            beat,
  input  logic [DW-1:0]   rd_data,
  output logic            wr_en,
  output logic [IDXW-1:0] wr_idx,
  output logic [DW-1:0]   wr_data
);
  logic keep;

  assign wr_idx  = IDXW'({ten, beat});
  assign keep    = int'(wr_idx) < int'(kept_for(wide_q));
  assign wr_en   = ack && keep;
  assign wr_data = rd_data;
endmodule

// File: rtl/ibf_fetch_seq.sv
`timescale 1ns/1ps
module ibf_fetch_seq
  import ibf_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int TENW = 2,
  parameter int IDXW = TENW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW-1:0]   base_addr,
  input  logic            struct_wide,
  input  logic            burst_en,
  output logic            bus_req,
  input  logic            bus_gnt,
  output logic            cyc,
  output logic            addr_valid,
  output logic [AW-1:0]   addr,
  output logic            data_phase,
  input  logic            data_rdy,
  input  logic [DW-1:0]   rd_data,
  output logic            wr_en,
  output logic [IDXW-1:0] wr_idx,
  output logic [DW-1:0]   wr_data,
  output logic            done
);
  ibf_state_e      state;
  logic [TENW-1:0] ten;
  logic            beat;
  logic            wide_q;
  logic            burst_q;
  logic            load;
  logic            ack;
  logic [AW-1:0]   cur_addr;

  ibf_fsm #(.TENW(TENW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .wide_in(struct_wide),
    .burst_in(burst_en), .bus_gnt(bus_gnt), .data_rdy(data_rdy),
    .state(state), .ten(ten), .beat(beat), .wide_q(wide_q),
    .burst_q(burst_q), .load(load)
  );

  ibf_addr_gen #(.AW(AW), .TENW(TENW)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(load), .base_in(base_addr),
    .ten(ten), .beat(beat), .cur_addr(cur_addr)
  );

  assign ack = (state == S_DATA) && data_rdy;

  ibf_wr_gate #(.DW(DW), .TENW(TENW), .IDXW(IDXW)) u_wr (
    .ack(ack), .wide_q(wide_q), .ten(ten), .beat(beat), .rd_data(rd_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  assign bus_req    = (state == S_REQ) || (state == S_ADDR) ||
                      (state == S_DATA) || (state == S_GAP);
  assign cyc        = (state == S_ADDR) || (state == S_DATA);
  assign addr_valid = (state == S_ADDR);
  assign addr       = addr_valid ? cur_addr : '0;
  assign data_phase = (state == S_DATA);
  assign done       = (state == S_FIN);
endmodule

// File: rtl/ibf_fetch_chk.sv
`timescale 1ns/1ps
module ibf_fetch_chk #(
  parameter int AW   = 32,
  parameter int IDXW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic          cyc,
  input logic          addr_valid,
  input logic [AW-1:0] addr,
  input logic          data_phase,
  input logic          data_rdy,
  input logic          wr_en,
  input logic          done,
  input logic          ack,
  input logic          beat,
  input logic          burst_q,
  input logic          wide_q
);
  logic [1:0] acks;
  logic [3:0] wcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acks <= '0;
    else if (!bus_req) acks <= '0;
    else if (ack)      acks <= acks + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wcnt <= '0;
    else if (done)   wcnt <= '0;
    else if (wr_en)  wcnt <= wcnt + 1'b1;
  end

  // R11
  cyc_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc |-> bus_gnt);
  // R6
  burst_one_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && burst_q) |-> !beat);
  // R7
  aligned_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> (addr[1:0] == 2'b00));
  // R5
  frame_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !beat && !burst_q) |=> !cyc);
  // R2
  two_per_tenure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |-> (acks == 2'd2));
  // R2
  no_third_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (acks < 2'd2));
  // R8
  req_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> !$past(bus_gnt));
  // R9
  done_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (wcnt == (wide_q ? 4'd7 : 4'd6)));
  // R12
  wr_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (data_rdy && data_phase));
endmodule

bind ibf_fetch_seq ibf_fetch_chk #(.AW(AW), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_gnt(bus_gnt), .cyc(cyc),
  .addr_valid(addr_valid), .addr(addr), .data_phase(data_phase),
  .data_rdy(data_rdy), .wr_en(wr_en), .done(done), .ack(ack), .beat(beat),
  .burst_q(burst_q), .wide_q(wide_q)
);

// File: tb/ibf_fetch_seq_test.sv
`timescale 1ns/1ps
module ibf_fetch_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] base_addr = '0;
  logic        struct_wide = 1'b0;
  logic        burst_en = 1'b0;
  logic        bus_req, cyc, addr_valid, data_phase, wr_en, done;
  logic        bus_gnt = 1'b0;
  logic        data_rdy = 1'b0;
  logic [31:0] rd_data = '0;
  logic [31:0] addr, wr_data;
  logic [2:0]  wr_idx;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // run state shared with the monitor
  logic [31:0] m_base;
  bit m_wide, m_burst, m_active;
  int wcount, acount, tcount, dcount, donecnt;

  always #10 clk = ~clk;

  ibf_fetch_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .struct_wide(struct_wide), .burst_en(burst_en), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .cyc(cyc), .addr_valid(addr_valid), .addr(addr),
    .data_phase(data_phase), .data_rdy(data_rdy), .rd_data(rd_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .done(done)
  );

  function automatic logic [31:0] memf(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_1234;
  endfunction
  function automatic int n_ten(input bit w);  return w ? 4 : 3; endfunction
  function automatic int n_keep(input bit w); return w ? 7 : 6; endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // bus arbiter and memory target
  initial begin : target
    logic [31:0] track = '0;
    bit pend = 0;
    forever begin
      @(negedge clk);
      if (!bus_req) bus_gnt = 1'b0;
      else if (!bus_gnt && ($urandom % 3 != 0)) bus_gnt = 1'b1;
      if (pend) track = track + 32'd4;
      pend = 0;
      if (addr_valid) track = addr;
      if (data_phase) begin
        data_rdy = ($urandom % 4 != 0);
        rd_data  = memf(track);
        pend     = data_rdy;
      end else begin
        data_rdy = 1'b0;
        rd_data  = $urandom;
      end
    end
  end

  // output monitor, samples a quarter period after the falling edge
  initial begin : monitor
    bit prev_req = 0, prev_first_ack = 0, prev_gnt = 0;
    forever begin
      @(negedge clk); #5;
      if (rst_n && m_active) begin
        if (prev_first_ack) begin
          if (!m_burst) check(!cyc, "R5", "cyc after first transfer", cyc, 0);
          else check(cyc && data_phase && !addr_valid, "R6", "burst continuation",
                     {cyc, data_phase, addr_valid}, 3'b110);
        end
        if (bus_req && !prev_req) begin
          check(!prev_gnt, "R8", "grant low before request", prev_gnt, 0);
          tcount++;
        end
        if (!bus_req && prev_req)
          check(dcount == 2 * tcount, "R2", "transfers at release", dcount, 2 * tcount);
        if (cyc) check(bus_gnt, "R11", "cyc without grant", bus_gnt, 1);
        if (addr_valid) begin
          logic [31:0] ea;
          ea = m_burst ? m_base + 32'(8 * acount) : m_base + 32'(4 * acount);
          check(addr == ea, "R7", "address", addr, ea);
          acount++;
        end
        if (wr_en) begin
          check(data_phase && data_rdy && wr_data == rd_data, "R12", "write on ready",
                wr_data, rd_data);
          check(wr_idx == 3'(wcount), "R12", "write index", wr_idx, wcount);
          check(wr_data == memf(m_base + 32'(4 * wcount)), m_wide ? "R3" : "R4",
                "write data", wr_data, memf(m_base + 32'(4 * wcount)));
          wcount++;
        end
        if (done) begin
          check(wcount == n_keep(m_wide) && dcount == 2 * n_ten(m_wide) && !bus_req,
                "R9", "done position", wcount, n_keep(m_wide));
          donecnt++;
        end
        prev_first_ack = data_phase && data_rdy && (dcount % 2 == 0);
        if (data_phase && data_rdy) dcount++;
      end else prev_first_ack = 0;
      prev_req = bus_req;
      prev_gnt = bus_gnt;
    end
  end

  task automatic run(input logic [31:0] base, input bit wide, input bit burst,
                     input bit poke);
    int guard = 0;
    m_base = {base[31:2], 2'b00}; m_wide = wide; m_burst = burst;
    wcount = 0; acount = 0; tcount = 0; dcount = 0; donecnt = 0;
    @(negedge clk);
    m_active = 1;
    base_addr = base; struct_wide = wide; burst_en = burst; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (donecnt == 0 && guard < 3000) begin
      @(negedge clk);
      guard++;
      if (poke && guard == 9) begin
        // R10: a second start mid-fetch with other settings
        base_addr = ~base; struct_wide = ~wide; burst_en = ~burst; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    end
    repeat (3) @(negedge clk);
    m_active = 0;
    check(donecnt == 1, "R9", "single done pulse", donecnt, 1);
    check(tcount == n_ten(wide), wide ? "R3" : "R4", "tenures", tcount, n_ten(wide));
    check(wcount == n_keep(wide), wide ? "R3" : "R4", "writes", wcount, n_keep(wide));
    check(acount == (burst ? 1 : 2) * n_ten(wide), burst ? "R6" : "R5",
          "address phases", acount, (burst ? 1 : 2) * n_ten(wide));
    if (poke)
      check(tcount == n_ten(wide) && wcount == n_keep(wide), "R10",
            "start ignored while busy", wcount, n_keep(wide));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd1234));
    m_active = 0;
    repeat (3) @(negedge clk);
    check({bus_req, cyc, addr_valid, data_phase, wr_en, done} == 6'b0, "R1",
          "reset outputs", {bus_req, cyc, addr_valid, data_phase, wr_en, done}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check({bus_req, cyc, addr_valid, data_phase, wr_en, done} == 6'b0, "R1",
          "idle outputs", {bus_req, cyc, addr_valid, data_phase, wr_en, done}, 0);
    // directed corners
    run(32'h0000_1000, 1'b1, 1'b0, 1'b0);
    run(32'h0000_2003, 1'b1, 1'b1, 1'b0);
    run(32'h8000_0040, 1'b0, 1'b0, 1'b0);
    run(32'hFFFF_FF00, 1'b0, 1'b1, 1'b0);
    run(32'h0001_0000, 1'b1, 1'b0, 1'b1);
    run(32'h0002_0004, 1'b0, 1'b1, 1'b1);
    // constrained random
    for (int i = 0; i < 16; i++)
      run($urandom & 32'hFFFF_FFF0 | ($urandom % 4), 1'($urandom), 1'($urandom), 1'(i % 5 == 0));
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule